// File: doc/BRIEF.md
# Half to Single Float Widener

This block widens a 16-bit half-precision floating-point bit pattern into the 32-bit single-precision bit pattern of the same value. Every half value has an exact single-precision equivalent, so the block never rounds. Subnormal half inputs come out as normal single values. A leading-zero count on the fraction sets how far each one is shifted and how much its exponent is lowered.

A mode input selects how the input is read. In IEEE mode (mode = 0) the all-ones exponent encodes infinity and NaN. In extended-range mode (mode = 1) the all-ones exponent is an ordinary finite exponent, so the output is always finite. The conversion logic is purely combinational and is followed by a single result register. An accepted input therefore appears on the output one clock later, qualified by out_valid.

Top module: `half_widen`

## Requirements
- R1: Output bit 31 always equals input bit 15 (the sign), for every class of input and in both modes.
- R2: For an input exponent (bits 14:10) in 1..30 in either mode, and for exponent 31 in mode 1, the output exponent (bits 30:23) is the input exponent plus 112. Output bits 22:13 equal input bits 9:0, and output bits 12:0 are zero.
- R3: For input exponent 0 with a non-zero fraction, let z be the number of leading zeros of the 10-bit fraction. The output exponent is 112 - z. The output fraction is the input fraction shifted left by z + 1, keeping its low 10 bits, placed at bits 22:13 with zeros below.
- R4: An input whose bits 14:0 are all zero gives an output whose bits 30:0 are all zero, so 0x0000 becomes 0x00000000 and 0x8000 becomes 0x80000000.
- R5: In mode 0, input exponent 31 gives output exponent 0xFF with input bits 9:0 at output bits 22:13 and zeros below. Infinity therefore stays infinity and NaN keeps its payload.
- R6: In mode 1, input exponent 31 gives output exponent 0x8F, so the output exponent is never 0xFF in that mode.
- R7: A sample accepted with in_valid high appears on out_data with out_valid high exactly one clock later. A cycle without in_valid gives out_valid low on the next clock, and out_data holds its previous value.
- R8: A clock edge with rst_n low clears out_valid, whatever in_valid is at that edge.
- R9: All 65536 input patterns give the exact single-precision value in each of the two modes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Qualifies in_data and mode for this cycle |
| in_data | input | 16 | Half-precision bit pattern |
| mode | input | 1 | 0 = IEEE encoding, 1 = extended-range encoding without infinity or NaN |
| out_valid | output | 1 | out_data holds a fresh result |
| out_data | output | 32 | Single-precision bit pattern |

## Verification
Each result is due exactly one rising edge after the edge that accepts its input. Nothing else in the block delays it, so that latency is fixed.

The driver changes inputs on falling edges and, for each accepted sample, pushes the expected word into a queue. The monitor samples on falling edges and pops one expected word each time it sees out_valid. As a result, every comparison falls on the half cycle after the rising edge that produced the result. Bubbles in the input stream must yield a cycle with out_valid low and the output held. A reset edge with in_valid high must yield no output at all.

// File: rtl/half_widen_pkg.sv
// Package: shared field widths and types for the half to single widener.
// Assumes IEEE-style layouts: sign, biased exponent, fraction, MSB first.
package half_widen_pkg;

    parameter int HW_EXP_IN   = 5;
    parameter int HW_FRAC_IN  = 10;
    parameter int HW_EXP_OUT  = 8;
    parameter int HW_FRAC_OUT = 23;

    // Interpretation of the all-ones input exponent
    typedef enum logic {
        WMODE_IEEE = 1'b0,
        WMODE_EXT  = 1'b1
    } widen_mode_e;

    // Classification of an input pattern
    typedef enum logic [1:0] {
        CLS_ZERO = 2'd0,
        CLS_SUB  = 2'd1,
        CLS_NORM = 2'd2,
        CLS_TOP  = 2'd3
    } widen_class_e;

endpackage

// File: rtl/half_widen_lzc.sv
// Module: leading-zero counter.
// Counts zeros above the highest set bit of vec; returns W when vec is zero.
// Assumes CW is wide enough to hold the value W.
module half_widen_lzc #(
    parameter int W  = 10,
    parameter int CW = $clog2(W + 1)
) (
    input  logic [W-1:0]  vec,
    output logic [CW-1:0] count,
    output logic          all_zero
);

    // Priority scan from LSB upward so that the highest set bit wins
    always_comb begin
        count = CW'(W);
        for (int i = 0; i < W; i++) begin
            if (vec[i]) begin
                count = CW'(W - 1 - i);
            end
        end
    end

    // Zero flag for the whole vector
    always_comb begin
        all_zero = (vec == '0);
    end

endmodule

// File: rtl/half_widen_core.sv
// Module: combinational half to single conversion.
// Classifies the input, renormalises subnormals through a leading-zero count
// and rebiases the exponent. Assumes the output exponent is wide enough that
// no rebiased or renormalised value can underflow (true for 5 -> 8 bits).
module half_widen_core
    import half_widen_pkg::*;
#(
    parameter int EXP_IN   = HW_EXP_IN,
    parameter int FRAC_IN  = HW_FRAC_IN,
    parameter int EXP_OUT  = HW_EXP_OUT,
    parameter int FRAC_OUT = HW_FRAC_OUT,
    localparam int IN_W    = 1 + EXP_IN + FRAC_IN,
    localparam int OUT_W   = 1 + EXP_OUT + FRAC_OUT
) (
    input  logic [IN_W-1:0]  half_in,
    input  widen_mode_e      mode,
    output logic [OUT_W-1:0] single_out
);

    localparam int BIAS_IN   = (1 << (EXP_IN - 1)) - 1;
    localparam int BIAS_OUT  = (1 << (EXP_OUT - 1)) - 1;
    localparam int BIAS_DIFF = BIAS_OUT - BIAS_IN;
    localparam int LZ_W      = $clog2(FRAC_IN + 1);
    localparam int PAD_W     = FRAC_OUT - FRAC_IN;

    logic                sgn;
    logic [EXP_IN-1:0]   exp_in;
    logic [FRAC_IN-1:0]  frac_in;
    logic [LZ_W-1:0]     lz;
    logic                frac_zero;
    widen_class_e        cls;
    logic [EXP_OUT-1:0]  exp_out;
    logic [FRAC_IN-1:0]  frac_out;
    logic [FRAC_IN-1:0]  frac_norm;

    // Split the input into its fields
    always_comb begin
        sgn     = half_in[IN_W-1];
        exp_in  = half_in[IN_W-2 -: EXP_IN];
        frac_in = half_in[FRAC_IN-1:0];
    end

    half_widen_lzc #(
        .W  (FRAC_IN),
        .CW (LZ_W)
    ) lzc_i (
        .vec      (frac_in),
        .count    (lz),
        .all_zero (frac_zero)
    );

    // Classify the input pattern
    always_comb begin
        if (exp_in == '0) begin
            cls = frac_zero ? CLS_ZERO : CLS_SUB;
        end else if (exp_in == '1) begin
            cls = CLS_TOP;
        end else begin
            cls = CLS_NORM;
        end
    end

    // Drop the leading one of a subnormal into the hidden-bit position
    always_comb begin
        frac_norm = frac_in << (lz + LZ_W'(1));
    end

    // Select exponent and fraction per class and mode
    always_comb begin
        unique case (cls)
            CLS_ZERO: begin
                exp_out  = '0;
                frac_out = '0;
            end
            CLS_SUB: begin
                exp_out  = EXP_OUT'(BIAS_DIFF) - EXP_OUT'(lz);
                frac_out = frac_norm;
            end
            CLS_TOP: begin
                exp_out  = (mode == WMODE_IEEE) ? '1
                                                : EXP_OUT'(exp_in) + EXP_OUT'(BIAS_DIFF);
                frac_out = frac_in;
            end
            default: begin
                exp_out  = EXP_OUT'(exp_in) + EXP_OUT'(BIAS_DIFF);
                frac_out = frac_in;
            end
        endcase
    end

    // Assemble the output word
    always_comb begin
        single_out = {sgn, exp_out, frac_out, {PAD_W{1'b0}}};
    end

endmodule

// File: rtl/half_widen_oreg.sv
// Module: output register with valid.
// Loads data when load is high, holds otherwise; valid follows load by one
// clock. Synchronous active-low reset clears valid and data.
module half_widen_oreg #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] d,
    output logic         q_valid,
    output logic [W-1:0] q
);

    // Valid flag tracks the load strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q_valid <= 1'b0;
        end else begin
            q_valid <= load;
        end
    end

    // Data register, enabled by load
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else if (load) begin
            q <= d;
        end
    end

endmodule

// File: rtl/half_widen.sv
// Module: half to single float widener, top level.
// One cycle from in_valid to out_valid; no back-pressure.
// Assumes mode is qualified by in_valid together with in_data.
module half_widen
    import half_widen_pkg::*;
#(
    parameter int EXP_IN   = HW_EXP_IN,
    parameter int FRAC_IN  = HW_FRAC_IN,
    parameter int EXP_OUT  = HW_EXP_OUT,
    parameter int FRAC_OUT = HW_FRAC_OUT,
    localparam int IN_W    = 1 + EXP_IN + FRAC_IN,
    localparam int OUT_W   = 1 + EXP_OUT + FRAC_OUT
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [IN_W-1:0]  in_data,
    input  logic             mode,
    output logic             out_valid,
    output logic [OUT_W-1:0] out_data
);

    logic [OUT_W-1:0] conv;
    widen_mode_e      mode_e;

    // Map the raw mode pin onto the package enum
    always_comb begin
        mode_e = widen_mode_e'(mode);
    end

    half_widen_core #(
        .EXP_IN   (EXP_IN),
        .FRAC_IN  (FRAC_IN),
        .EXP_OUT  (EXP_OUT),
        .FRAC_OUT (FRAC_OUT)
    ) core_i (
        .half_in    (in_data),
        .mode       (mode_e),
        .single_out (conv)
    );

    half_widen_oreg #(
        .W (OUT_W)
    ) oreg_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (in_valid),
        .d       (conv),
        .q_valid (out_valid),
        .q       (out_data)
    );

endmodule

// File: rtl/half_widen_chk.sv
// Module: assertion checker for half_widen, bound to every instance.
// Written for the default 16 -> 32 bit layout.
module half_widen_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        in_valid,
    input logic [15:0] in_data,
    input logic        mode,
    input logic        out_valid,
    input logic [31:0] out_data
);

    p_reset_clears_r8: assert property (@(posedge clk)
        !rst_n |=> !out_valid);

    p_valid_latency_r7: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    p_bubble_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && $stable(out_data)));

    p_sign_pass_r1: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> (out_data[31] == $past(in_data[15])));

    p_zero_keep_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_data[14:0] == 15'd0) |=> (out_data[30:0] == 31'd0));

    p_ieee_special_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !mode && in_data[14:10] == 5'h1F)
        |=> (out_data[30:23] == 8'hFF && out_data[22:13] == $past(in_data[9:0])));

    p_ext_finite_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && mode) |=> (out_data[30:23] != 8'hFF));

    p_low_bits_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> (out_data[12:0] == 13'd0));

endmodule

bind half_widen half_widen_chk chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_data   (in_data),
    .mode      (mode),
    .out_valid (out_valid),
    .out_data  (out_data)
);

// File: tb/half_widen_tb_top.sv
// Bench: exhaustive scoreboard for half_widen in both modes.
module half_widen_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [15:0] in_data = '0;
    logic        mode = 1'b0;
    logic        out_valid;
    logic [31:0] out_data;

    int          n_checks = 0;
    int          n_errors = 0;
    logic [31:0] exp_q[$];
    string       tag_q[$];
    logic [31:0] last_exp = '0;
    bit          finished = 1'b0;

    always #10 clk = ~clk;  // 50 MHz

    half_widen dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_data   (in_data),
        .mode      (mode),
        .out_valid (out_valid),
        .out_data  (out_data)
    );

    // Reference model, derived from the requirements by bit-level reasoning
    function automatic logic [31:0] ref_widen(input logic [15:0] h, input logic m,
                                              output string tag);
        logic       s;
        logic [4:0] e;
        logic [9:0] f;
        logic [22:0] fr;
        int         p;
        s = h[15];
        e = h[14:10];
        f = h[9:0];
        if (e == 0 && f == 0) begin
            tag = "R4";
            return {s, 31'd0};
        end
        if (e == 0) begin
            p = 0;
            for (int i = 0; i < 10; i++) if (f[i]) p = i;
            fr = 23'(f) << (23 - p);
            tag = "R3";
            return {s, 8'(103 + p), fr};
        end
        if (e == 5'd31 && !m) begin
            tag = "R5";
            return {s, 8'hFF, f, 13'd0};
        end
        if (e == 5'd31) begin
            tag = "R6";
            return {s, 8'd143, f, 13'd0};
        end
        tag = "R2";
        return {s, 8'(e) + 8'd112, f, 13'd0};
    endfunction

    task automatic check(input bit ok, input string tag,
                         input logic [31:0] act, input logic [31:0] expv);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s: actual=%08h expected=%08h", tag, act, expv);
        end
    endtask

    // Driver: present one sample and push its expected result
    task automatic drive(input logic [15:0] h, input logic m);
        string t;
        logic [31:0] e;
        @(negedge clk);
        in_valid = 1'b1;
        in_data  = h;
        mode     = m;
        e = ref_widen(h, m, t);
        exp_q.push_back(e);
        tag_q.push_back(t);
        last_exp = e;
    endtask

    task automatic idle();
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    // Monitor: compare each valid output with the queue head (R9 stream)
    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R7 unexpected out_valid", out_data, 32'd0);
            end else begin
                logic [31:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check(out_data == e, {t, " R9"}, out_data, e);
            end
        end
    end

    // Watchdog
    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_errors++;
            $display("FAIL R7 watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        // R8: reset state
        repeat (3) @(negedge clk);
        check(out_valid == 1'b0, "R8 reset", {31'd0, out_valid}, 32'd0);
        @(negedge clk);
        rst_n = 1'b1;

        // Directed corner values (R1, R4, R5, R6, R3)
        drive(16'h0000, 1'b0);
        drive(16'h8000, 1'b0);
        drive(16'h7C00, 1'b0);
        drive(16'hFE01, 1'b0);
        drive(16'h7FFF, 1'b1);
        drive(16'h0001, 1'b0);
        drive(16'h83FF, 1'b1);
        idle();
        // R7: bubble gives no output and holds data
        @(negedge clk);
        check(out_valid == 1'b0, "R7 bubble valid", {31'd0, out_valid}, 32'd0);
        check(out_data == last_exp, "R7 bubble hold", out_data, last_exp);

        // R9: exhaustive sweep in both modes with periodic bubbles
        for (int m = 0; m < 2; m++) begin
            for (int v = 0; v < 65536; v++) begin
                drive(16'(v), 1'(m));
                if ((v % 4099) == 4098) idle();
            end
        end
        idle();
        repeat (2) @(negedge clk);
        check(exp_q.size() == 0, "R7 drained", 32'(exp_q.size()), 32'd0);
        check(out_valid == 1'b0, "R7 idle valid", {31'd0, out_valid}, 32'd0);
        check(out_data == last_exp, "R7 idle hold", out_data, last_exp);

        // R8: reset edge with in_valid high yields no output
        @(negedge clk);
        rst_n    = 1'b0;
        in_valid = 1'b1;
        in_data  = 16'h3C00;
        @(negedge clk);
        check(out_valid == 1'b0, "R8 reset with in_valid", {31'd0, out_valid}, 32'd0);
        in_valid = 1'b0;
        rst_n    = 1'b1;
        @(negedge clk);
        check(out_valid == 1'b0, "R8 after reset", {31'd0, out_valid}, 32'd0);

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule